// File: doc/BRIEF.md
# Change-Triggered Phase Increment Loader

This block carries a frequency control word for a numerically controlled oscillator from the register side of a chip into the sample clock domain. The word arrives as a static bundle of discretes from the control clock domain. No handshake comes with it. The loader passes each bit through its own synchronizer chain and waits until the synchronized word has held one value for a set number of consecutive sample cycles. It then compares that settled word with the last word it delivered.

When the settled word differs from the last delivered word, the block raises a one-cycle write strobe toward the oscillator's configuration port and presents the new word with it. When the word has not changed, nothing is written. After reset, the first settled word is delivered once, whatever its value, so the oscillator always starts from a defined frequency. A shadow output holds the last delivered word so that control logic can read it back.

Top module: `pinc_loader`

## Requirements
- R1: While reset is asserted, `nco_wr` is 0, and `nco_pinc` and `pinc_shadow` are both 0.
- R2: After reset is released, the word on `pinc_async` is delivered exactly once with one strobe, even when it is 0.
- R3: A word is accepted only after the synchronized copy has shown that value on MATCH_CYCLES consecutive sample cycles (default 2). A value that is present on the input for a single sample cycle is never delivered.
- R4: A settled word equal to the last delivered word produces no strobe.
- R5: `nco_wr` is high for exactly one sample cycle per delivery. During that cycle `nco_pinc` carries the new word, and `nco_pinc` keeps that word until the next delivery.
- R6: `pinc_shadow` always equals the last delivered word and changes only in a cycle in which `nco_wr` is high.
- R7: With defaults, if a new input word is first sampled at rising edge E1, `nco_wr` is high during the cycle that follows rising edge E5. The delay is two synchronizer stages, two match cycles and one write-state cycle.
- R8: Successive distinct words, each held long enough to settle, are each delivered once and in order. A, then B, then A again gives two strobes after the initial load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| pinc_async | input | 16 | Phase increment discretes from the control domain, asynchronous to clk |
| nco_wr | output | 1 | One-cycle write strobe to the oscillator configuration port |
| nco_pinc | output | 16 | Phase increment word presented to the oscillator |
| pinc_shadow | output | 16 | Last delivered word, for read-back |

## Verification
The bench holds a word on the input for a single sample cycle before returning it to its old value. A design without the match filter would load that transient and then reload the old word, giving two extra strobes. The bench also rewrites the current word and checks that there is no strobe; a design that writes continuously or on every settle event would strobe there. It checks the first load after reset with an input of zero, which a design that compares against the reset value of the shadow would skip. It measures the exact strobe cycle and width, and any extra pipeline stage or stretched pulse shows up there.

// File: rtl/pinc_ld_pkg.sv
package pinc_ld_pkg;

  typedef enum logic [1:0] {
    LD_BOOT   = 2'd0,
    LD_IDLE   = 2'd1,
    LD_STROBE = 2'd2
  } ld_state_e;

  localparam int unsigned CNT_W = 4;

  // Saturating increment of a match counter up to lim.
  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] c,
                                               input logic [CNT_W-1:0] lim);
    return (c >= lim) ? lim : c + 1'b1;
  endfunction

  // Delivery decision: first word after reset always, afterwards only on change.
  function automatic logic must_deliver(input logic        settled,
                                        input logic        first_pending,
                                        input logic [31:0] cand,
                                        input logic [31:0] last);
    return settled && (first_pending || (cand != last));
  endfunction

endpackage

// File: rtl/pinc_sync.sv
module pinc_sync #(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync,
  output logic             q_valid
);

  logic [STAGES-1:0] prime_q;

  // One flop chain per bit; every bit settles independently.
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_async[b]};
    end
    assign q_sync[b] = chain_q[STAGES-1];
  end

  // Marks when the chains hold sampled input rather than reset contents.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prime_q <= '0;
    else        prime_q <= {prime_q[STAGES-2:0], 1'b1};
  end
  assign q_valid = prime_q[STAGES-1];

endmodule

// File: rtl/pinc_settle.sv
module pinc_settle
  import pinc_ld_pkg::*;
#(
  parameter int unsigned WIDTH       = 16,
  parameter int unsigned MATCH_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] in_word,
  input  logic             in_valid,
  output logic             settled,
  output logic [WIDTH-1:0] settled_word
);

  localparam logic [CNT_W-1:0] LIM = CNT_W'(MATCH_CYCLES);

  logic [WIDTH-1:0] cand_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_q <= '0;
      cnt_q  <= '0;
    end else if (!in_valid) begin
      cnt_q  <= '0;
    end else if (cnt_q == '0 || in_word != cand_q) begin
      cand_q <= in_word;
      cnt_q  <= CNT_W'(1);
    end else begin
      cnt_q  <= sat_inc(cnt_q, LIM);
    end
  end

  assign settled      = (cnt_q == LIM);
  assign settled_word = cand_q;

endmodule

// File: rtl/pinc_write_fsm.sv
module pinc_write_fsm
  import pinc_ld_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             settled,
  input  logic [WIDTH-1:0] settled_word,
  output logic             wr_strobe,
  output logic [WIDTH-1:0] wr_word,
  output logic [WIDTH-1:0] last_word,
  output logic             load_done,
  output logic             deliver_evt
);

  ld_state_e        state_q, state_d;
  logic [WIDTH-1:0] word_q;
  logic [WIDTH-1:0] last_q;

  assign deliver_evt = (state_q != LD_STROBE) &&
                       must_deliver(settled, state_q == LD_BOOT,
                                    32'(settled_word), 32'(last_q));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      LD_BOOT, LD_IDLE: if (deliver_evt) state_d = LD_STROBE;
      LD_STROBE:        state_d = LD_IDLE;
      default:          state_d = LD_BOOT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LD_BOOT;
      word_q  <= '0;
      last_q  <= '0;
    end else begin
      state_q <= state_d;
      if (deliver_evt) begin
        word_q <= settled_word;
        last_q <= settled_word;
      end
    end
  end

  assign wr_strobe = (state_q == LD_STROBE);
  assign wr_word   = word_q;
  assign last_word = last_q;
  assign load_done = (state_q != LD_BOOT);

endmodule

// File: rtl/pinc_loader.sv
module pinc_loader #(
  parameter int unsigned WIDTH        = 16,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned MATCH_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pinc_async,
  output logic             nco_wr,
  output logic [WIDTH-1:0] nco_pinc,
  output logic [WIDTH-1:0] pinc_shadow
);

  logic [WIDTH-1:0] sync_word;
  logic             sync_valid;
  logic             settle_hit;
  logic [WIDTH-1:0] settle_word;
  logic             load_done;
  logic             deliver_evt;

  pinc_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (pinc_async),
    .q_sync  (sync_word),
    .q_valid (sync_valid)
  );

  pinc_settle #(.WIDTH(WIDTH), .MATCH_CYCLES(MATCH_CYCLES)) u_settle (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_word      (sync_word),
    .in_valid     (sync_valid),
    .settled      (settle_hit),
    .settled_word (settle_word)
  );

  pinc_write_fsm #(.WIDTH(WIDTH)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .settled      (settle_hit),
    .settled_word (settle_word),
    .wr_strobe    (nco_wr),
    .wr_word      (nco_pinc),
    .last_word    (pinc_shadow),
    .load_done    (load_done),
    .deliver_evt  (deliver_evt)
  );

endmodule

// File: rtl/pinc_loader_chk.sv
module pinc_loader_chk #(
  parameter int unsigned WIDTH        = 16,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned MATCH_CYCLES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             nco_wr,
  input logic [WIDTH-1:0] nco_pinc,
  input logic [WIDTH-1:0] pinc_shadow,
  input logic [WIDTH-1:0] sync_word,
  input logic             load_done
);

  localparam bit DEFAULT_PIPE = (MATCH_CYCLES == 2);

  // R5: strobe lasts one cycle
  assert_single_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    nco_wr |=> !nco_wr);

  // R5: word held between strobes
  assert_word_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !nco_wr |-> $stable(nco_pinc));

  // R6: shadow moves only with a strobe and matches the delivered word
  assert_shadow_moves_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pinc_shadow != $past(pinc_shadow)) |-> nco_wr);
  assert_shadow_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    nco_wr |-> (nco_pinc == pinc_shadow));

  // R4: after the first load, a strobe always carries a new value
  assert_change_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (nco_wr && $past(load_done)) |-> (nco_pinc != $past(pinc_shadow)));

  // R3: the delivered word was present at the synchronizer output on two straight cycles
  assert_settled_twice_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (DEFAULT_PIPE && nco_wr) |->
      ($past(sync_word, 2) == nco_pinc && $past(sync_word, 3) == nco_pinc));

  // R2: first strobe after reset ends the boot phase
  assert_boot_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_done) |-> nco_wr);

endmodule

bind pinc_loader pinc_loader_chk #(
  .WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES), .MATCH_CYCLES(MATCH_CYCLES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .nco_wr      (nco_wr),
  .nco_pinc    (nco_pinc),
  .pinc_shadow (pinc_shadow),
  .sync_word   (sync_word),
  .load_done   (load_done)
);

// File: tb/test_pinc_loader.sv
module test_pinc_loader;

  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] pinc_async = '0;
  logic         nco_wr;
  logic [W-1:0] nco_pinc;
  logic [W-1:0] pinc_shadow;

  int checks = 0;
  int fails  = 0;
  int strobes = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pinc_loader i_pinc_loader (
    .clk         (clk),
    .rst_n       (rst_n),
    .pinc_async  (pinc_async),
    .nco_wr      (nco_wr),
    .nco_pinc    (nco_pinc),
    .pinc_shadow (pinc_shadow)
  );

  always @(posedge clk) if (rst_n && nco_wr) strobes++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // R1 and R2: reset state, then a single load of zero
  task automatic t_reset_zero();
    rst_n = 1'b0;
    pinc_async = 16'h0000;
    idle(3);
    check("R1 nco_wr in reset", nco_wr, 0);
    check("R1 nco_pinc in reset", nco_pinc, 0);
    check("R1 shadow in reset", pinc_shadow, 0);
    strobes = 0;
    rst_n = 1'b1;
    idle(12);
    check("R2 zero loaded once", strobes, 1);
    check("R2 shadow after zero load", pinc_shadow, 16'h0000);
  endtask

  // R2: nonzero word present at reset release
  task automatic t_reset_value();
    rst_n = 1'b0;
    pinc_async = 16'h1234;
    idle(3);
    strobes = 0;
    rst_n = 1'b1;
    idle(12);
    check("R2 one initial strobe", strobes, 1);
    check("R2 initial word", nco_pinc, 16'h1234);
    check("R6 shadow initial", pinc_shadow, 16'h1234);
  endtask

  // R7 and R5: exact latency and one-cycle width
  task automatic t_latency();
    pinc_async = 16'hA5C3;        // sampled at next edge E1
    idle(4);                      // after E4
    check("R7 no strobe before E5", nco_wr, 0);
    check("R6 shadow unchanged before E5", pinc_shadow, 16'h1234);
    idle(1);                      // after E5
    check("R7 strobe after E5", nco_wr, 1);
    check("R5 word during strobe", nco_pinc, 16'hA5C3);
    idle(1);
    check("R5 strobe one cycle", nco_wr, 0);
    check("R5 word held", nco_pinc, 16'hA5C3);
    check("R6 shadow updated", pinc_shadow, 16'hA5C3);
  endtask

  // R4: same value again gives nothing
  task automatic t_same_value();
    strobes = 0;
    pinc_async = 16'hA5C3;
    idle(12);
    check("R4 no strobe on equal word", strobes, 0);
    check("R4 word unchanged", nco_pinc, 16'hA5C3);
  endtask

  // R3: one-cycle transient rejected, two-cycle value accepted
  task automatic t_transient();
    strobes = 0;
    pinc_async = 16'hFFFF;
    idle(1);
    pinc_async = 16'hA5C3;
    idle(12);
    check("R3 one-cycle value rejected", strobes, 0);
    check("R3 word after transient", nco_pinc, 16'hA5C3);
    check("R3 shadow after transient", pinc_shadow, 16'hA5C3);
    strobes = 0;
    pinc_async = 16'h0F0F;
    idle(2);
    pinc_async = 16'hA5C3;
    idle(14);
    check("R3 two-cycle value accepted then reverted", strobes, 2);
    check("R3 final word", nco_pinc, 16'hA5C3);
  endtask

  // R8: A, B, A sequence
  task automatic t_sequence();
    strobes = 0;
    pinc_async = 16'h4000;
    idle(10);
    check("R8 first word", nco_pinc, 16'h4000);
    pinc_async = 16'h8001;
    idle(10);
    check("R8 second word", nco_pinc, 16'h8001);
    pinc_async = 16'h4000;
    idle(10);
    check("R8 back to first", nco_pinc, 16'h4000);
    check("R8 strobe count", strobes, 3);
    check("R6 shadow final", pinc_shadow, 16'h4000);
  endtask

  initial begin
    fork
      begin
        t_reset_zero();
        t_reset_value();
        t_latency();
        t_same_value();
        t_transient();
        t_sequence();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule